// File: doc/BRIEF.md
# Dual-Port Mailbox and Port Decoder

This block is the control front end of a two-port, two-direction FIFO device. Port A and port B each have a chip select, a write/read select, an enable and a mailbox select, and each runs on its own clock. The block decodes these pins into write and read strobes for the two FIFO arrays, which sit outside the block. It also decodes them into output-enable signals for the data buses. The write/read select has opposite polarity on the two ports. On port A a high level means write. On port B a high level means read.

When the mailbox select is high, the port cycle goes to a one-word bypass register instead of a FIFO. Mailbox 1 carries words from A to B, and mailbox 2 carries words from B to A. Each mailbox has a flag in the writer's clock domain that is high while the mailbox is empty. It also has a ready flag in the reader's clock domain. The two clock domains exchange toggle events through two-flop synchronizers, so the clocks may be fully asynchronous.

Top module: `dual_mailbox_port`

## Requirements
- R1: `a_oe` is high exactly when `csa_n` is low and `wra` is low. This holds regardless of `ena`.
- R2: `b_oe` is high exactly when `csb_n` is low and `wrb` is high. This holds regardless of `enb`.
- R3: On port A, with `csa_n` low, `ena` high and `mba` low:
  - with `wra` high, `fifo1_wr` equals `fifo1_wr_ok`;
  - with `wra` low, `fifo2_rd` equals `fifo2_rd_ok`.
- R4: On port B, with `csb_n` low, `enb` high and `mbb` low:
  - with `wrb` low, `fifo2_wr` equals `fifo2_wr_ok`;
  - with `wrb` high, `fifo1_rd` equals `fifo1_rd_ok`.
- R5: While a port's enable is low, the port raises no FIFO strobe, and no clock edge changes its mailbox flags. This holds whatever the other control pins are.
- R6: A FIFO write strobe is never raised while its ready input (`fifo1_wr_ok`, `fifo2_wr_ok`) is low. A FIFO read strobe is never raised while its data-valid input (`fifo1_rd_ok`, `fifo2_rd_ok`) is low.
- R7: A mailbox write is a write cycle with the mailbox select high while the writer's flag (`mbf1` or `mbf2`) is high. On the writer's clock edge it captures the data-in bus and drives that flag low.
- R8: A mailbox write attempted while the writer's flag is low is ignored. The stored word and the flag are unchanged.
- R9: The reader's ready flag (`mb1_ready_b`, `mb2_ready_a`) rises on the second reader clock edge after the edge that wrote the mailbox. A mailbox read attempted while the ready flag is low is ignored.
- R10: A mailbox read is a read cycle with the mailbox select high while the ready flag is high. It drops the ready flag on that reader edge. The writer's flag returns high on the second writer clock edge after the read.
- R11: While `rst_n` is low, `mbf1` and `mbf2` are high, both ready flags are low, and both stored words are zero.
- R12: `a_dout` shows the mailbox 2 word while `mba` is high and `fifo2_q` otherwise. `b_dout` shows the mailbox 1 word while `mbb` is high and `fifo1_q` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| csa_n | input | 1 | Port A chip select, active low |
| wra | input | 1 | Port A direction: 1 write, 0 read |
| ena | input | 1 | Port A cycle enable |
| mba | input | 1 | Port A mailbox select |
| a_din | input | W | Port A write data |
| a_dout | output | W | Port A read data |
| a_oe | output | 1 | Port A bus drive enable |
| fifo1_wr_ok | input | 1 | FIFO1 has a free location |
| fifo2_rd_ok | input | 1 | FIFO2 has a word to read |
| fifo2_q | input | W | FIFO2 output word |
| fifo1_wr | output | 1 | FIFO1 write strobe (clk_a) |
| fifo2_rd | output | 1 | FIFO2 read strobe (clk_a) |
| mbf1 | output | 1 | Mailbox 1 empty flag, clk_a domain |
| mb2_ready_a | output | 1 | Mailbox 2 holds an unread word, clk_a domain |
| csb_n | input | 1 | Port B chip select, active low |
| wrb | input | 1 | Port B direction: 1 read, 0 write |
| enb | input | 1 | Port B cycle enable |
| mbb | input | 1 | Port B mailbox select |
| b_din | input | W | Port B write data |
| b_dout | output | W | Port B read data |
| b_oe | output | 1 | Port B bus drive enable |
| fifo2_wr_ok | input | 1 | FIFO2 has a free location |
| fifo1_rd_ok | input | 1 | FIFO1 has a word to read |
| fifo1_q | input | W | FIFO1 output word |
| fifo2_wr | output | 1 | FIFO2 write strobe (clk_b) |
| fifo1_rd | output | 1 | FIFO1 read strobe (clk_b) |
| mbf2 | output | 1 | Mailbox 2 empty flag, clk_b domain |
| mb1_ready_b | output | 1 | Mailbox 1 holds an unread word, clk_b domain |

## Verification
The block produces its results at different times:
- The strobes, the output enables and the data muxes are combinational. They are due in the same cycle as the pins that drive them.
- A writer's flag falls at the first writer edge after the write.
- The reader's ready flag rises at the second reader edge after the write.
- After a read, the writer's flag recovers at the second writer edge.

The two clocks run at equal frequency and half a period apart. The bench changes inputs 1 ns after each port B edge. It samples port A outputs 1 ns before the port A edge and port B outputs 2 ns before the port B edge. A behavioural model counts those edge latencies per event and is compared at every sample point. Directed checks land on the exact edge where each flag is due. Some of them probe mailbox reads placed one edge too early, to show that those reads are ignored.

// File: rtl/dual_mailbox_port.sv
module dual_mailbox_port #(
  parameter int W = 36
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         csa_n,
  input  logic         wra,
  input  logic         ena,
  input  logic         mba,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         a_oe,
  input  logic         fifo1_wr_ok,
  input  logic         fifo2_rd_ok,
  input  logic [W-1:0] fifo2_q,
  output logic         fifo1_wr,
  output logic         fifo2_rd,
  output logic         mbf1,
  output logic         mb2_ready_a,
  input  logic         csb_n,
  input  logic         wrb,
  input  logic         enb,
  input  logic         mbb,
  input  logic [W-1:0] b_din,
  output logic [W-1:0] b_dout,
  output logic         b_oe,
  input  logic         fifo2_wr_ok,
  input  logic         fifo1_rd_ok,
  input  logic [W-1:0] fifo1_q,
  output logic         fifo2_wr,
  output logic         fifo1_rd,
  output logic         mbf2,
  output logic         mb1_ready_b
);

  logic [W-1:0] mail1, mail2;
  logic         t1w, t1r, t2w, t2r;
  logic [1:0]   s_r1, s_w2, s_r2, s_w1;

  wire a_wcyc = !csa_n && ena && wra;
  wire a_rcyc = !csa_n && ena && !wra;
  wire b_wcyc = !csb_n && enb && !wrb;
  wire b_rcyc = !csb_n && enb && wrb;

  wire mb1_wr = a_wcyc && mba && mbf1;
  wire mb2_rd = a_rcyc && mba && mb2_ready_a;
  wire mb2_wr = b_wcyc && mbb && mbf2;
  wire mb1_rd = b_rcyc && mbb && mb1_ready_b;

  assign a_oe     = !csa_n && !wra;
  assign b_oe     = !csb_n && wrb;
  assign fifo1_wr = a_wcyc && !mba && fifo1_wr_ok;
  assign fifo2_rd = a_rcyc && !mba && fifo2_rd_ok;
  assign fifo2_wr = b_wcyc && !mbb && fifo2_wr_ok;
  assign fifo1_rd = b_rcyc && !mbb && fifo1_rd_ok;

  assign a_dout = mba ? mail2 : fifo2_q;
  assign b_dout = mbb ? mail1 : fifo1_q;

  assign mbf1        = (t1w == s_r1[1]);
  assign mb1_ready_b = (s_w1[1] != t1r);
  assign mbf2        = (t2w == s_r2[1]);
  assign mb2_ready_a = (s_w2[1] != t2r);

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      mail1 <= '0;
      t1w   <= 1'b0;
      t2r   <= 1'b0;
      s_r1  <= '0;
      s_w2  <= '0;
    end else begin
      s_r1 <= {s_r1[0], t1r};
      s_w2 <= {s_w2[0], t2w};
      if (mb1_wr) begin
        mail1 <= a_din;
        t1w   <= ~t1w;
      end
      if (mb2_rd) t2r <= ~t2r;
    end
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      mail2 <= '0;
      t2w   <= 1'b0;
      t1r   <= 1'b0;
      s_r2  <= '0;
      s_w1  <= '0;
    end else begin
      s_r2 <= {s_r2[0], t2r};
      s_w1 <= {s_w1[0], t1w};
      if (mb2_wr) begin
        mail2 <= b_din;
        t2w   <= ~t2w;
      end
      if (mb1_rd) t1r <= ~t1r;
    end
  end

endmodule

// File: rtl/mailbox_port_checker.sv
module mailbox_port_checker (
  input logic clk_a,
  input logic clk_b,
  input logic rst_n,
  input logic csa_n,
  input logic wra,
  input logic ena,
  input logic mba,
  input logic a_oe,
  input logic fifo1_wr,
  input logic fifo2_rd,
  input logic fifo1_wr_ok,
  input logic mbf1,
  input logic csb_n,
  input logic wrb,
  input logic enb,
  input logic mbb,
  input logic b_oe,
  input logic fifo2_wr,
  input logic mb1_ready_b
);

  assert_a_dir_R1: assert property (@(posedge clk_a) disable iff (!rst_n)
    fifo1_wr |-> !a_oe);

  assert_b_dir_R2: assert property (@(posedge clk_b) disable iff (!rst_n)
    fifo2_wr |-> !b_oe);

  assert_idle_R5: assert property (@(posedge clk_a) disable iff (!rst_n)
    !ena |-> (!fifo1_wr && !fifo2_rd));

  assert_gate_R6: assert property (@(posedge clk_a) disable iff (!rst_n)
    fifo1_wr |-> fifo1_wr_ok);

  assert_fill_R7: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!csa_n && wra && ena && mba && mbf1) |=> !mbf1);

  assert_ready_R9: assert property (@(posedge clk_b) disable iff (!rst_n)
    $rose(mb1_ready_b) |-> !mbf1);

  assert_drain_R10: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!csb_n && wrb && enb && mbb && mb1_ready_b) |=> !mb1_ready_b);

endmodule

bind dual_mailbox_port mailbox_port_checker u_chk (.*);

// File: tb/tb_dual_mailbox_port.sv
module tb_dual_mailbox_port;
  localparam int W = 36;

  logic clk_a = 1'b0, clk_b = 1'b1, rst_n = 1'b0;
  logic csa_n = 1'b1, wra = 1'b0, ena = 1'b0, mba = 1'b0;
  logic csb_n = 1'b1, wrb = 1'b0, enb = 1'b0, mbb = 1'b0;
  logic fifo1_wr_ok = 1'b0, fifo2_rd_ok = 1'b0, fifo2_wr_ok = 1'b0, fifo1_rd_ok = 1'b0;
  logic [W-1:0] a_din = '0, b_din = '0;
  logic [W-1:0] fifo1_q = 36'h1_1111_2222, fifo2_q = 36'hA_5A5A_5A5A;
  logic [W-1:0] a_dout, b_dout;
  logic a_oe, b_oe, fifo1_wr, fifo2_rd, fifo2_wr, fifo1_rd;
  logic mbf1, mbf2, mb1_ready_b, mb2_ready_a;

  always #5 clk_a = ~clk_a;
  always #5 clk_b = ~clk_b;

  dual_mailbox_port #(.W(W)) dut (.*);

  int checks = 0, fails = 0;

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  logic [W-1:0] m_mail1 = '0, m_mail2 = '0;
  logic m_mbf1 = 1'b1, m_mbf2 = 1'b1, m_rdy1 = 1'b0, m_rdy2 = 1'b0;
  int ca1 = 0, ca2 = 0, cb1 = 0, cb2 = 0;

  always @(posedge clk_a or posedge clk_b) begin
    if (!rst_n) begin
      m_mail1 = '0; m_mail2 = '0; m_mbf1 = 1; m_mbf2 = 1; m_rdy1 = 0; m_rdy2 = 0;
      ca1 = 0; ca2 = 0; cb1 = 0; cb2 = 0;
    end else if (clk_a) begin
      automatic bit wr1 = !csa_n && ena && wra && mba && m_mbf1;
      automatic bit rd2 = !csa_n && ena && !wra && mba && m_rdy2;
      if (ca1 > 0) begin ca1--; if (ca1 == 0) m_mbf1 = 1; end
      if (ca2 > 0) begin ca2--; if (ca2 == 0) m_rdy2 = 1; end
      if (wr1) begin m_mail1 = a_din; m_mbf1 = 0; cb1 = 2; end
      if (rd2) begin m_rdy2 = 0; cb2 = 2; end
    end else begin
      automatic bit wr2 = !csb_n && enb && !wrb && mbb && m_mbf2;
      automatic bit rd1 = !csb_n && enb && wrb && mbb && m_rdy1;
      if (cb1 > 0) begin cb1--; if (cb1 == 0) m_rdy1 = 1; end
      if (cb2 > 0) begin cb2--; if (cb2 == 0) m_mbf2 = 1; end
      if (wr2) begin m_mail2 = b_din; m_mbf2 = 0; ca2 = 2; end
      if (rd1) begin m_rdy1 = 0; ca1 = 2; end
    end
  end

  initial forever begin
    @(posedge clk_b);
    #4;
    if (rst_n) begin
      chk(a_oe, !csa_n && !wra, "R1 model a_oe");
      chk(fifo1_wr, !csa_n && ena && wra && !mba && fifo1_wr_ok, "R3 model fifo1_wr");
      chk(fifo2_rd, !csa_n && ena && !wra && !mba && fifo2_rd_ok, "R3 model fifo2_rd");
      chk(mbf1, m_mbf1, "R7 model mbf1");
      chk(mb2_ready_a, m_rdy2, "R9 model mb2_ready_a");
      chk(a_dout, mba ? m_mail2 : fifo2_q, "R12 model a_dout");
    end
    #4;
    if (rst_n) begin
      chk(b_oe, !csb_n && wrb, "R2 model b_oe");
      chk(fifo2_wr, !csb_n && enb && !wrb && !mbb && fifo2_wr_ok, "R4 model fifo2_wr");
      chk(fifo1_rd, !csb_n && enb && wrb && !mbb && fifo1_rd_ok, "R4 model fifo1_rd");
      chk(mbf2, m_mbf2, "R7 model mbf2");
      chk(mb1_ready_b, m_rdy1, "R9 model mb1_ready_b");
      chk(b_dout, mbb ? m_mail1 : fifo1_q, "R12 model b_dout");
    end
  end

  task automatic nxt();
    @(posedge clk_b);
    #1;
  endtask

  task automatic idle();
    csa_n = 1; wra = 0; ena = 0; mba = 0;
    csb_n = 1; wrb = 0; enb = 0; mbb = 0;
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    #3;
    chk(mbf1, 1, "R11 reset mbf1");
    chk(mbf2, 1, "R11 reset mbf2");
    chk(mb1_ready_b, 0, "R11 reset mb1_ready_b");
    chk(mb2_ready_a, 0, "R11 reset mb2_ready_a");
    mba = 1; mbb = 1; #1;
    chk(a_dout, 0, "R11 reset mail2");
    chk(b_dout, 0, "R11 reset mail1");
    idle();
    nxt(); rst_n = 1;
    nxt();

    csa_n = 0; wra = 1; ena = 1; mba = 0; fifo1_wr_ok = 1; #1;
    chk(fifo1_wr, 1, "R3 fifo1 write");
    chk(a_oe, 0, "R1 write cycle no drive");
    fifo1_wr_ok = 0; #1;
    chk(fifo1_wr, 0, "R6 fifo1 write blocked");
    nxt();
    wra = 0; fifo2_rd_ok = 1; #1;
    chk(fifo2_rd, 1, "R3 fifo2 read");
    chk(a_oe, 1, "R1 read cycle drive");
    chk(a_dout, fifo2_q, "R12 a_dout fifo path");
    fifo2_rd_ok = 0; #1;
    chk(fifo2_rd, 0, "R6 fifo2 read blocked");
    csa_n = 1; #1;
    chk(a_oe, 0, "R1 deselected");
    nxt(); idle();

    csb_n = 0; wrb = 0; enb = 1; fifo2_wr_ok = 1; #1;
    chk(fifo2_wr, 1, "R4 fifo2 write");
    chk(b_oe, 0, "R2 write cycle no drive");
    wrb = 1; fifo1_rd_ok = 1; #1;
    chk(fifo1_rd, 1, "R4 fifo1 read");
    chk(b_oe, 1, "R2 read cycle drive");
    chk(b_dout, fifo1_q, "R12 b_dout fifo path");
    fifo1_rd_ok = 0; #1;
    chk(fifo1_rd, 0, "R6 fifo1 read blocked");
    nxt(); idle();

    csa_n = 0; wra = 1; ena = 0; mba = 1; a_din = 36'hF_0F0F_0F0F;
    csb_n = 0; wrb = 0; enb = 0; mbb = 1; b_din = 36'h7_7777_7777;
    fifo1_wr_ok = 1; fifo2_wr_ok = 1;
    nxt();
    chk(mbf1, 1, "R5 disabled mailbox1 write");
    chk(mbf2, 1, "R5 disabled mailbox2 write");
    mba = 0; mbb = 0; #1;
    chk(fifo1_wr, 0, "R5 disabled fifo1 strobe");
    chk(fifo2_wr, 0, "R5 disabled fifo2 strobe");
    idle(); fifo1_wr_ok = 0; fifo2_wr_ok = 0;
    nxt();

    csa_n = 0; wra = 1; ena = 1; mba = 1; a_din = 36'h1_2345_6789;
    nxt();
    idle();
    chk(mbf1, 0, "R7 mailbox1 fills");
    chk(mb1_ready_b, 0, "R9 not yet ready");
    csb_n = 0; wrb = 1; enb = 1; mbb = 1;
    nxt();
    enb = 0;
    chk(mb1_ready_b, 1, "R9 ready after two edges, early read ignored");
    chk(b_dout, 36'h1_2345_6789, "R7 mailbox1 data");

    csa_n = 0; wra = 1; ena = 1; mba = 1; a_din = 36'hD_EAD0_BEEF;
    nxt();
    csa_n = 1; ena = 0; mba = 0;
    chk(b_dout, 36'h1_2345_6789, "R8 second write ignored");
    chk(mbf1, 0, "R8 flag stays low");

    enb = 1;
    nxt();
    enb = 0;
    chk(mb1_ready_b, 0, "R10 read clears ready");
    chk(mbf1, 0, "R10 writer flag not yet back");
    nxt();
    chk(mbf1, 0, "R10 writer flag after one edge");
    nxt();
    chk(mbf1, 1, "R10 writer flag back after two edges");
    idle();
    nxt();

    csb_n = 0; wrb = 0; enb = 1; mbb = 1; b_din = 36'h3_CAFE_F00D;
    nxt();
    enb = 0; csb_n = 1; mbb = 0;
    chk(mbf2, 0, "R7 mailbox2 fills");
    chk(mb2_ready_a, 0, "R9 mailbox2 not yet ready");
    csa_n = 0; wra = 0; ena = 1; mba = 1;
    nxt();
    ena = 0;
    chk(mb2_ready_a, 0, "R9 mailbox2 ready pending");
    nxt();
    chk(mb2_ready_a, 1, "R9 mailbox2 ready, early read ignored");
    chk(a_dout, 36'h3_CAFE_F00D, "R12 a_dout mailbox path");
    ena = 1;
    nxt();
    ena = 0;
    chk(mb2_ready_a, 0, "R10 mailbox2 read clears ready");
    chk(mbf2, 0, "R10 mbf2 still low");
    nxt();
    chk(mbf2, 1, "R10 mbf2 back high");
    idle();
    repeat (4) nxt();
    finish_up();
  end
endmodule